// File: doc/BRIEF.md
# Single-Shot Successive-Approximation Conversion Controller

This block sequences one successive-approximation conversion at a time for an external analog front end. The analog comparator and trial DAC are outside the block. The block presents a trial code on `dac_code` and reads back a one-bit decision on `cmp_in`, which is 1 when the analog input is at or above the trial level. Software programs a control register and a mode register through a simple write port. It then sets a run flag. The block derives a conversion rate from its own clock, runs a sampling phase and then the bit-by-bit search, and stores the result in one of eight per-channel result slots.

The register view has these fields. In the control register (address 0), bits [2:0] pick the channel, bit 3 is the trigger select, bits [5:4] hold the rate code, and bit 7 is the run flag. In the mode register (address 1), bit 0 picks 10-bit resolution and bit 1 enables sample-and-hold. Result slot c is read as a low byte at address 16+2c and a high byte at address 17+2c. Reads return data one clock after the address is presented. Channel, resolution, rate and sample-and-hold are captured when a conversion starts, so the registers may be rewritten while a conversion runs.

Top module: `adc_oneshot_ctrl`

## Requirements
- R1: Control bits [2:0] value c (000 = channel 0 up to 111 = channel 7) routes the result of a conversion to slot c only. Slot c reads at address 16+2c (low byte) and 17+2c (high byte), and other slots keep their contents.
- R2: Mode bit 0 selects 8 trial bits when 0 and 10 trial bits when 1. Trials run MSB first, and a trial bit is kept when `cmp_in` is 1, so a comparator that reports "input >= trial" yields the input value.
- R3: The low byte of a slot holds result bits [7:0]. In 10-bit mode, bits [1:0] of the high byte hold result bits [9:8].
- R4: In 8-bit mode the high byte of the written slot reads 0, and `dac_code[9:8]` stays 0 throughout the conversion.
- R5: Rate code {bit5, bit4} sets the clocks per conversion step: 11 gives 1, 01 gives 2, 10 gives 3, 00 gives 4. A conversion spans rate × (sampling steps + trial bits) clocks, counted from the clock edge that accepts the start write to the clock edge after which `done` is high.
- R6: Writing the control register with bit 7 = 1 and bit 3 = 0 while idle starts a conversion. Control reads return channel, trigger and rate fields in place, and bit 7 reads 1 exactly while a conversion runs.
- R7: A control write with bit 3 = 1 never starts a conversion.
- R8: Mode bit 1 = 1 gives a sampling phase of 4 steps. Mode bit 1 = 0 gives 2 steps.
- R9: Channel, resolution, rate and sample-and-hold are captured at start. Register writes during a conversion do not change its timing, its width or its destination slot.
- R10: On completion the slot is written, the run flag and `busy` clear, and `done` is high for exactly one clock.
- R11: A control write with bit 7 = 0 during a conversion stops it at once. The slot keeps its old value and no `done` pulse is produced.
- R12: After reset both registers read 0, and `busy`, `done`, `sampling` and `dac_code` are 0.
- R13: `sampling` is high exactly for the sampling phase. `dac_code` is 0 whenever no trial is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dac_code | output | 10 | Trial code driven to the external DAC |
| sampling | output | 1 | High during the sampling phase |
| busy | output | 1 | High while a conversion runs |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read data, one clock after `addr` |

## Verification
The hardest cases to reach are a register write that lands inside a running conversion. That write may be an abort during sampling, an abort during the trial phase, or a rewrite of channel, rate and resolution that must be ignored. Every bus access in the bench takes exactly one clock. The bench therefore counts clocks from the accepting edge and places each such write at a chosen step of the sequence. It then checks the total duration, the destination slot and the absence of `done`. The result path is swept over every 8-bit and every 10-bit input value at full rate, and over all sixteen combinations of rate, resolution and sample-and-hold.

// File: rtl/adc_pkg.sv
package adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } sar_state_e;

  localparam int FS_W    = 2;
  localparam int RATIO_W = 3;

  // clocks per conversion step for a rate code
  function automatic logic [RATIO_W-1:0] div_ratio(input logic [FS_W-1:0] fs);
    case (fs)
      2'b11:   return RATIO_W'(1);
      2'b01:   return RATIO_W'(2);
      2'b10:   return RATIO_W'(3);
      default: return RATIO_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [FS_W-1:0] fs,
  output logic            tick
);

  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] last;

  always_comb last = div_ratio(fs) - RATIO_W'(1);
  always_comb tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + RATIO_W'(1);
    end
  end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int LO_W       = 8,
  parameter int CH_W       = 3,
  parameter int SAMP_LONG  = 4,
  parameter int SAMP_SHORT = 2
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp_in,
  input  logic [CH_W-1:0]  ch_in,
  input  logic             res_hi_in,
  input  logic             sh_in,
  output logic             busy,
  output logic             sampling,
  output logic             done,
  output logic             res_hi,
  output logic [RES_W-1:0] dac_code,
  output logic             wr_en,
  output logic [CH_W-1:0]  wr_ch,
  output logic [RES_W-1:0] wr_data
);

  localparam int IDX_W  = $clog2(RES_W);
  localparam int SCNT_W = $clog2(SAMP_LONG + 1);

  sar_state_e        state;
  logic [SCNT_W-1:0] scnt;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  msb;
  logic [RES_W-1:0]  code;
  logic [RES_W-1:0]  kept;
  logic [CH_W-1:0]   ch_l;
  logic              res_l;
  logic              last_bit;

  always_comb msb = res_l ? IDX_W'(RES_W - 1) : IDX_W'(LO_W - 1);

  // trial value after this step's comparator decision
  always_comb begin
    kept = code;
    if (!cmp_in) kept[idx] = 1'b0;
  end

  always_comb last_bit = (state == ST_CONV) && tick && !abort && (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      scnt     <= '0;
      idx      <= '0;
      code     <= '0;
      ch_l     <= '0;
      res_l    <= 1'b0;
      done     <= 1'b0;
      sampling <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_SAMPLE;
            sampling <= 1'b1;
            scnt     <= sh_in ? SCNT_W'(SAMP_LONG - 1) : SCNT_W'(SAMP_SHORT - 1);
            ch_l     <= ch_in;
            res_l    <= res_hi_in;
            code     <= '0;
          end
        end
        ST_SAMPLE: begin
          if (abort) begin
            state    <= ST_IDLE;
            sampling <= 1'b0;
          end else if (tick) begin
            if (scnt == '0) begin
              state    <= ST_CONV;
              sampling <= 1'b0;
              idx      <= msb;
              code     <= RES_W'(1) << msb;
            end else begin
              scnt <= scnt - SCNT_W'(1);
            end
          end
        end
        ST_CONV: begin
          if (abort) begin
            state <= ST_IDLE;
            code  <= '0;
          end else if (tick) begin
            if (idx == '0) begin
              state <= ST_IDLE;
              code  <= '0;
              done  <= 1'b1;
            end else begin
              code <= kept | (RES_W'(1) << (idx - IDX_W'(1)));
              idx  <= idx - IDX_W'(1);
            end
          end
        end
        default: begin
          state    <= ST_IDLE;
          sampling <= 1'b0;
          code     <= '0;
        end
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign res_hi   = res_l;
  assign dac_code = code;
  assign wr_en    = last_bit;
  assign wr_ch    = ch_l;
  assign wr_data  = kept;

endmodule

// File: rtl/adc_result_mem.sv
module adc_result_mem #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 10,
  parameter int IDX_W  = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/adc_oneshot_ctrl.sv
module adc_oneshot_ctrl
  import adc_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int RES_W      = 10,
  parameter int LO_W       = 8,
  parameter int DW         = 8,
  parameter int AW         = 5,
  parameter int SAMP_LONG  = 4,
  parameter int SAMP_SHORT = 2,
  parameter int RES_BASE   = 16
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             sampling,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rdata
);

  localparam int CH_W    = $clog2(NCH);
  localparam int HI_W    = RES_W - LO_W;
  localparam int B_TRIG  = CH_W;
  localparam int FS_LO   = CH_W + 1;
  localparam int B_START = DW - 1;
  localparam int B_RES   = 0;
  localparam int B_SH    = 1;
  localparam int A_CTRL  = 0;
  localparam int A_MODE  = 1;

  logic [CH_W-1:0]  ch_q;
  logic             trig_q;
  logic [FS_W-1:0]  fs_q;
  logic [FS_W-1:0]  conv_fs;
  logic             res_q;
  logic             sh_q;
  logic             wr_ctrl, wr_mode;
  logic             start_go, abort_go;
  logic             tick;
  logic             conv_res;
  logic             core_we;
  logic [CH_W-1:0]  core_ch;
  logic [RES_W-1:0] core_data;
  logic [RES_W-1:0] store_data;
  logic [RES_W-1:0] mem_q;
  logic [AW-1:0]    roff;
  logic             res_hit;
  logic [CH_W-1:0]  rd_ch;
  logic             res_sel_q, hi_q;
  logic [DW-1:0]    reg_q;
  logic [DW-1:0]    ctrl_view;
  logic [DW-1:0]    mode_view;

  always_comb wr_ctrl  = wr_en && (addr == AW'(A_CTRL));
  always_comb wr_mode  = wr_en && (addr == AW'(A_MODE));
  always_comb start_go = wr_ctrl && wdata[B_START] && !wdata[B_TRIG] && !busy;
  always_comb abort_go = wr_ctrl && !wdata[B_START] && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q    <= '0;
      trig_q  <= 1'b0;
      fs_q    <= '0;
      res_q   <= 1'b0;
      sh_q    <= 1'b0;
      conv_fs <= '0;
    end else begin
      if (wr_ctrl) begin
        ch_q   <= wdata[CH_W-1:0];
        trig_q <= wdata[B_TRIG];
        fs_q   <= wdata[FS_LO +: FS_W];
      end
      if (wr_mode) begin
        res_q <= wdata[B_RES];
        sh_q  <= wdata[B_SH];
      end
      if (start_go) conv_fs <= wdata[FS_LO +: FS_W];
    end
  end

  adc_clk_div u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .fs   (conv_fs),
    .tick (tick)
  );

  adc_sar_core #(
    .RES_W      (RES_W),
    .LO_W       (LO_W),
    .CH_W       (CH_W),
    .SAMP_LONG  (SAMP_LONG),
    .SAMP_SHORT (SAMP_SHORT)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .start     (start_go),
    .abort     (abort_go),
    .tick      (tick),
    .cmp_in    (cmp_in),
    .ch_in     (wdata[CH_W-1:0]),
    .res_hi_in (res_q),
    .sh_in     (sh_q),
    .busy      (busy),
    .sampling  (sampling),
    .done      (done),
    .res_hi    (conv_res),
    .dac_code  (dac_code),
    .wr_en     (core_we),
    .wr_ch     (core_ch),
    .wr_data   (core_data)
  );

  always_comb store_data = conv_res ? core_data
                                    : {{HI_W{1'b0}}, core_data[LO_W-1:0]};

  always_comb roff    = addr - AW'(RES_BASE);
  always_comb res_hit = (addr >= AW'(RES_BASE)) && (roff < AW'(2 * NCH));
  always_comb rd_ch   = roff[CH_W:1];

  adc_result_mem #(
    .DEPTH  (NCH),
    .DATA_W (RES_W)
  ) u_mem (
    .clk   (clk),
    .we    (core_we),
    .waddr (core_ch),
    .wdata (store_data),
    .raddr (rd_ch),
    .rdata (mem_q)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CH_W-1:0]       = ch_q;
    ctrl_view[B_TRIG]         = trig_q;
    ctrl_view[FS_LO +: FS_W]  = fs_q;
    ctrl_view[B_START]        = busy;
    mode_view        = '0;
    mode_view[B_RES] = res_q;
    mode_view[B_SH]  = sh_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      res_sel_q <= 1'b0;
      hi_q      <= 1'b0;
    end else begin
      res_sel_q <= res_hit;
      hi_q      <= roff[0];
      if (addr == AW'(A_CTRL))      reg_q <= ctrl_view;
      else if (addr == AW'(A_MODE)) reg_q <= mode_view;
      else                          reg_q <= '0;
    end
  end

  always_comb begin
    if (!res_sel_q)  rdata = reg_q;
    else if (hi_q)   rdata = DW'(mem_q[RES_W-1:LO_W]);
    else             rdata = mem_q[LO_W-1:0];
  end

endmodule

// File: rtl/adc_oneshot_chk.sv
module adc_oneshot_chk #(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  parameter int CH_W  = 3
)(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic             busy,
  input logic             done,
  input logic             sampling,
  input logic [RES_W-1:0] dac_code,
  input logic             conv_res
);

  localparam int B_START = DW - 1;
  localparam int B_TRIG  = CH_W;

  logic ctrl_wr;
  always_comb ctrl_wr = wr_en && (addr == '0);

  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[B_START] && !wdata[B_TRIG] && !busy) |=> busy); // R6

  AST_TRIG_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[B_TRIG] && !busy) |=> !busy); // R7

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wdata[B_START] && busy) |=> (!busy && !done)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10

  AST_SAMPLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    sampling |-> (busy && dac_code == '0)); // R13

  AST_IDLE_DAC: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dac_code == '0)); // R13

  AST_NARROW_DAC: assert property (@(posedge clk) disable iff (rst)
    (busy && !conv_res) |-> (dac_code[RES_W-1:LO_W] == '0)); // R4

endmodule

bind adc_oneshot_ctrl adc_oneshot_chk #(
  .AW    (AW),
  .DW    (DW),
  .RES_W (RES_W),
  .LO_W  (LO_W),
  .CH_W  (CH_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .busy     (busy),
  .done     (done),
  .sampling (sampling),
  .dac_code (dac_code),
  .conv_res (conv_res)
);

// File: tb/adc_oneshot_ctrl_tb.sv
module adc_oneshot_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic       sampling, busy, done;
  logic [7:0] rdata;
  logic [9:0] vin = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  // ideal comparator: input at or above the trial level
  assign cmp_in = (dac_code <= vin);

  adc_oneshot_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cmp_in(cmp_in), .dac_code(dac_code), .sampling(sampling),
    .busy(busy), .done(done), .rdata(rdata)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; addr = 5'(a); wdata = 8'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    addr = 5'(a);
    @(posedge clk); @(negedge clk);
    v = int'(rdata);
  endtask

  function automatic int ratio(int fs);
    case (fs)
      3: return 1;
      1: return 2;
      2: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int ctrl_word(int start, int fs, int trig, int ch);
    return (start << 7) | (fs << 4) | (trig << 3) | ch;
  endfunction

  task automatic conv_check(int ch, int fs, int res, int sh, int v);
    int n, samp, got, steps;
    steps = (sh != 0 ? 4 : 2) + (res != 0 ? 10 : 8);
    vin = 10'(v);
    wr(1, (sh << 1) | res);
    wr(0, ctrl_word(1, fs, 0, ch));
    chk("R6 busy after start", int'(busy), 1);
    n = 0; samp = 0;
    while (!done && n < 500) begin
      if (sampling) samp++;
      @(posedge clk); @(negedge clk);
      n++;
    end
    chk("R5 R8 conversion clocks", n, ratio(fs) * steps);
    chk("R13 sampling clocks", samp, ratio(fs) * (sh != 0 ? 4 : 2));
    chk("R10 busy clear at done", int'(busy), 0);
    @(posedge clk); @(negedge clk);
    chk("R10 done one clock", int'(done), 0);
    rd(0, got);
    chk("R6 run flag clear", (got >> 7) & 1, 0);
    rd(16 + 2 * ch, got);
    chk("R1 R2 R3 low byte", got, v & 255);
    rd(17 + 2 * ch, got);
    chk("R3 R4 high byte", got, res != 0 ? (v >> 8) : 0);
  endtask

  task automatic abort_case(int wait_cyc);
    int got, seen;
    conv_check(3, 3, 0, 0, 8'h55);
    vin = 10'h0AA;
    wr(1, 2);
    wr(0, ctrl_word(1, 3, 0, 3));
    for (int i = 1; i < wait_cyc; i++) begin
      @(posedge clk); @(negedge clk);
    end
    chk("R6 running flag", int'(busy), 1);
    wr(0, ctrl_word(0, 3, 0, 3));
    chk("R11 busy drops on abort", int'(busy), 0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (done) seen = 1;
      @(posedge clk); @(negedge clk);
    end
    chk("R11 no done after abort", seen, 0);
    rd(16 + 6, got);
    chk("R11 slot unchanged", got, 8'h55);
  endtask

  initial begin
    int got, n, seen;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 busy", int'(busy), 0);
    chk("R12 done", int'(done), 0);
    chk("R12 sampling", int'(sampling), 0);
    chk("R12 dac_code", int'(dac_code), 0);
    rd(0, got); chk("R12 control reg", got, 0);
    rd(1, got); chk("R12 mode reg", got, 0);

    // all rate, resolution and sample-and-hold combinations
    for (int fs = 0; fs < 4; fs++)
      for (int res = 0; res < 2; res++)
        for (int sh = 0; sh < 2; sh++)
          conv_check((fs * 4 + res * 2 + sh) % 8, fs, res, sh,
                     res != 0 ? (fs * 211 + sh * 97 + 300) % 1024
                              : (fs * 53 + sh * 31 + 7) % 256);

    // exhaustive values in both widths (R2)
    for (int v = 0; v < 256; v++)  conv_check(v % 8, 3, 0, 0, v);
    for (int v = 0; v < 1024; v++) conv_check((v + 3) % 8, 3, 1, 0, v);

    // R4: an 8-bit result clears a prior 10-bit high byte
    conv_check(5, 3, 1, 0, 10'h3C5);
    conv_check(5, 3, 0, 1, 8'h5A);

    // R1: slots are independent
    conv_check(1, 1, 0, 0, 8'h11);
    conv_check(6, 1, 0, 0, 8'h66);
    rd(16 + 2, got); chk("R1 slot 1 kept", got, 8'h11);

    // R7: trigger bit set blocks the start
    wr(0, ctrl_word(1, 3, 1, 4));
    chk("R7 no start", int'(busy), 0);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      if (done || busy) seen = 1;
      @(posedge clk); @(negedge clk);
    end
    chk("R7 stays idle", seen, 0);
    rd(0, got); chk("R6 R7 control readback", got, 8'h3C);

    // R9: mid-run writes are ignored by the running conversion
    vin = 10'h09C;
    wr(1, 2);
    wr(0, ctrl_word(1, 0, 0, 2));
    n = 0;
    @(posedge clk); @(negedge clk); n++;
    wr(1, 1); n++;
    wr(0, ctrl_word(1, 3, 0, 6)); n++;
    while (!done && n < 500) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
    chk("R9 timing kept", n, 4 * (4 + 8));
    @(posedge clk); @(negedge clk);
    rd(16 + 4, got); chk("R9 destination kept", got, 8'h9C);
    rd(17 + 4, got); chk("R9 width kept", got, 0);
    rd(16 + 12, got); chk("R9 other slot untouched", got, 8'h66);

    // R11: abort in sampling phase and in trial phase
    abort_case(2);
    abort_case(8);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule